// File: doc/BRIEF.md
# Erase Range Block Walker

This block turns a single erase request, given as a byte start address and a byte length, into a series of per-block erase commands for a flash array. The array has two regions with different block sizes. A small-block region of 8 blocks of 16 KiB (4096 words of 4 bytes) starts at address 0. A large-block region of 31 blocks of 128 KiB (32768 words of 4 bytes) follows it directly at byte 0x20000. The whole array is 4 MiB (0x400000 bytes).

A request is accepted on a valid/ready handshake and then checked. If it passes, the walker issues one erase command per block in ascending order and waits for each to complete. The step size follows the region that holds the current address. A separate command sequencer carries out each block erase on the flash bus and answers with done, plus a fail flag when the erase went wrong. When the walk ends, or the request is rejected, the walker presents a one-cycle status.

The controller steps through five named states:

- `ST_IDLE`: ready, waiting for a request.
- `ST_CHECK`: evaluates the range.
- `ST_ISSUE`: pulses one erase command.
- `ST_WAIT`: waits for the sequencer's answer.
- `ST_REPORT`: presents the status for one cycle.

Its transitions are:

- `ST_IDLE`→`ST_CHECK` when a request is accepted.
- `ST_CHECK`→`ST_REPORT` for a zero-length or rejected request.
- `ST_CHECK`→`ST_ISSUE` for a legal request.
- `ST_ISSUE`→`ST_WAIT` always.
- `ST_WAIT`→`ST_ISSUE` when a block is done and more remain.
- `ST_WAIT`→`ST_REPORT` on a failure or when the last block is done.
- `ST_REPORT`→`ST_IDLE` always.

Top module: `erase_range_walker`

## Requirements
- R1: `req_ready` is 1 in idle. It is 0 from the cycle after a request is accepted (`req_valid` and `req_ready` both 1 at a rising edge) until the cycle after `sts_valid`. `sts_valid` is high for exactly one cycle per request.
- R2: A request with length 0 completes with status code 0 (ok) and issues no erase, whatever its start address.
- R3: A non-zero request whose end (start plus length, computed without wrap-around) exceeds 0x400000 completes with status code 1 (invalid) and issues no erase.
- R4: A non-zero request whose start is not a multiple of the block size of its region is invalid (code 1). The block size is 0x4000 below 0x20000 and 0x20000 at or above it.
- R5: A non-zero request whose end is not a multiple of the block size of the region containing the end is invalid (code 1). An end below 0x20000 uses 0x4000; an end at or above it uses 0x20000.
- R6: For a legal request, `ers_go` pulses for one cycle with `ers_addr` at the block base. No further pulse occurs until `ers_done` has been seen. The next pulse comes in the cycle after that `ers_done`.
- R7: After each successful block, the address advances by the block size of the region it was in. The walk therefore switches from 0x4000 steps to 0x20000 steps on reaching 0x20000, and erases blocks in ascending order.
- R8: If `ers_done` arrives with `ers_fail` 1, the request ends with code 2 (I/O failure) and no further block is erased.
- R9: A legal request ends with code 0 once the block ending at start plus length reports done without failure.
- R10: `ers_done` has no effect while no erase is outstanding.
- R11: Status appears 2 cycles after the accepting edge when no erase is issued. Each erased block adds (sequencer latency + 1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Walker can accept a request |
| req_start | input | 32 | Byte start address of the range |
| req_len | input | 32 | Byte length of the range |
| ers_go | output | 1 | One-cycle block erase command |
| ers_addr | output | 32 | Base byte address of the block to erase |
| ers_done | input | 1 | Sequencer finished the current block |
| ers_fail | input | 1 | Qualifies `ers_done`: the block erase failed |
| sts_valid | output | 1 | One-cycle final status strobe |
| sts_code | output | 2 | 0 ok, 1 invalid, 2 I/O failure |

## Verification
For a rejected or zero-length request, the status strobe is due on the second falling edge after the accepting edge. The first erase command is due on that same falling edge for a legal request. Each later command, and the final status, follows one cycle after the falling edge where `ers_done` was driven. The bench's reference model counts falling edges from acceptance and holds the expected latency for the whole request, computed from the number of blocks and the responder's delay. Ready, every erase address and the status are compared on every falling edge, away from the rising edge where the design changes them.

// File: rtl/erw_pkg.sv
package erw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_WAIT,
        ST_REPORT
    } erw_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_INVALID = 2'd1,
        RES_IOFAIL  = 2'd2
    } erw_result_e;

endpackage

// File: rtl/erw_region.sv
// Maps a byte address to the block size of the region holding it and
// reports whether the address sits on a block boundary of that region.
module erw_region #(
    parameter int          XW          = 33,
    parameter int unsigned BOUNDARY    = 32'h0002_0000,
    parameter int unsigned SMALL_BYTES = 32'h0000_4000,
    parameter int unsigned LARGE_BYTES = 32'h0002_0000
) (
    input  logic [XW-1:0] addr,
    output logic [XW-1:0] blk_bytes,
    output logic          aligned
);
    localparam logic [XW-1:0] EDGE_X  = XW'(BOUNDARY);
    localparam logic [XW-1:0] SMALL_X = XW'(SMALL_BYTES);
    localparam logic [XW-1:0] LARGE_X = XW'(LARGE_BYTES);

    always_comb begin
        blk_bytes = (addr < EDGE_X) ? SMALL_X : LARGE_X;
        aligned   = ((addr & (blk_bytes - XW'(1))) == '0);
    end
endmodule

// File: rtl/erw_range_check.sv
// Judges a latched request: zero length, or illegal by range or alignment.
module erw_range_check #(
    parameter int          XW          = 33,
    parameter int unsigned BOUNDARY    = 32'h0002_0000,
    parameter int unsigned TOTAL       = 32'h0040_0000,
    parameter int unsigned SMALL_BYTES = 32'h0000_4000,
    parameter int unsigned LARGE_BYTES = 32'h0002_0000
) (
    input  logic [XW-1:0] start_addr,
    input  logic [XW-1:0] byte_len,
    output logic          zero_len,
    output logic          bad
);
    localparam logic [XW-1:0] TOTAL_X = XW'(TOTAL);

    logic [XW-1:0] end_addr;
    logic [XW-1:0] unused_start_step;
    logic [XW-1:0] unused_end_step;
    logic          start_al;
    logic          end_al;

    assign end_addr = start_addr + byte_len;

    erw_region #(
        .XW(XW), .BOUNDARY(BOUNDARY),
        .SMALL_BYTES(SMALL_BYTES), .LARGE_BYTES(LARGE_BYTES)
    ) u_start_rgn (
        .addr(start_addr), .blk_bytes(unused_start_step), .aligned(start_al)
    );

    erw_region #(
        .XW(XW), .BOUNDARY(BOUNDARY),
        .SMALL_BYTES(SMALL_BYTES), .LARGE_BYTES(LARGE_BYTES)
    ) u_end_rgn (
        .addr(end_addr), .blk_bytes(unused_end_step), .aligned(end_al)
    );

    always_comb begin
        zero_len = (byte_len == '0);
        bad      = (end_addr > TOTAL_X) || !start_al || !end_al;
    end
endmodule

// File: rtl/erase_range_walker.sv
module erase_range_walker
    import erw_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WORD_BYTES  = 4,
    parameter int SMALL_WORDS = 4096,
    parameter int SMALL_COUNT = 8,
    parameter int LARGE_WORDS = 32768,
    parameter int LARGE_COUNT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_start,
    input  logic [ADDR_W-1:0] req_len,
    output logic              ers_go,
    output logic [ADDR_W-1:0] ers_addr,
    input  logic              ers_done,
    input  logic              ers_fail,
    output logic              sts_valid,
    output logic [1:0]        sts_code
);
    localparam int          XW          = ADDR_W + 1;
    localparam int unsigned SMALL_BYTES = WORD_BYTES * SMALL_WORDS;
    localparam int unsigned LARGE_BYTES = WORD_BYTES * LARGE_WORDS;
    localparam int unsigned BOUNDARY    = SMALL_BYTES * SMALL_COUNT;
    localparam int unsigned TOTAL       = BOUNDARY + LARGE_BYTES * LARGE_COUNT;

    erw_state_e    state_q;
    erw_result_e   code_q;
    logic [XW-1:0] addr_q;
    logic [XW-1:0] rem_q;
    logic [XW-1:0] step;
    logic          walk_al;
    logic          chk_zero;
    logic          chk_bad;

    erw_range_check #(
        .XW(XW), .BOUNDARY(BOUNDARY), .TOTAL(TOTAL),
        .SMALL_BYTES(SMALL_BYTES), .LARGE_BYTES(LARGE_BYTES)
    ) u_check (
        .start_addr(addr_q), .byte_len(rem_q),
        .zero_len(chk_zero), .bad(chk_bad)
    );

    erw_region #(
        .XW(XW), .BOUNDARY(BOUNDARY),
        .SMALL_BYTES(SMALL_BYTES), .LARGE_BYTES(LARGE_BYTES)
    ) u_walk_rgn (
        .addr(addr_q), .blk_bytes(step), .aligned(walk_al)
    );

    // State register and the request bookkeeping it carries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= RES_OK;
            addr_q  <= '0;
            rem_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= {1'b0, req_start};
                        rem_q   <= {1'b0, req_len};
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (chk_zero) begin
                        code_q  <= RES_OK;
                        state_q <= ST_REPORT;
                    end else if (chk_bad) begin
                        code_q  <= RES_INVALID;
                        state_q <= ST_REPORT;
                    end else begin
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (ers_done) begin
                        if (ers_fail) begin
                            code_q  <= RES_IOFAIL;
                            state_q <= ST_REPORT;
                        end else begin
                            addr_q <= addr_q + step;
                            rem_q  <= rem_q - step;
                            if (rem_q == step) begin
                                code_q  <= RES_OK;
                                state_q <= ST_REPORT;
                            end else begin
                                state_q <= ST_ISSUE;
                            end
                        end
                    end
                end
                ST_REPORT: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state register.
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        ers_go    = (state_q == ST_ISSUE);
        ers_addr  = addr_q[ADDR_W-1:0];
        sts_valid = (state_q == ST_REPORT);
        sts_code  = code_q;
    end

    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R1
    ready_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_valid |=> (req_ready && !sts_valid));

    // R6
    single_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_go |=> !ers_go);

    // R7
    go_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ers_go |-> (walk_al && ({1'b0, ers_addr} < XW'(TOTAL))));

    // R7
    remaining_covers_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (rem_q >= step));

    // R8
    fail_reported_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_valid && sts_code == 2'd2) |-> $past(ers_done && ers_fail));
endmodule

// File: tb/erase_range_walker_bench.sv
module erase_range_walker_bench;
    localparam longint BND = 64'h2_0000;
    localparam longint TOT = 64'h40_0000;
    localparam longint SB  = 64'h4000;
    localparam longint LB  = 64'h2_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_start = '0;
    logic [31:0] req_len = '0;
    logic        ers_go;
    logic [31:0] ers_addr;
    logic        ers_done;
    logic        ers_fail;
    logic        sts_valid;
    logic [1:0]  sts_code;

    logic rsp_done = 1'b0;
    logic rsp_fail = 1'b0;
    logic idle_done = 1'b0;
    assign ers_done = rsp_done | idle_done;
    assign ers_fail = rsp_fail;

    erase_range_walker u_erase_range_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_start(req_start), .req_len(req_len),
        .ers_go(ers_go), .ers_addr(ers_addr),
        .ers_done(ers_done), .ers_fail(ers_fail),
        .sts_valid(sts_valid), .sts_code(sts_code)
    );

    always #2.5 clk = ~clk;

    int     checks = 0;
    int     failures = 0;
    int     cyc = 0;
    longint exp_q[$];
    int     m_code = 0;
    int     m_lat = 0;
    bit     m_busy = 1'b0;
    int     m_cnt = 0;
    int     rsp_lat = 1;
    int     rsp_cnt = 0;
    longint fail_at = -1;
    longint pend = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Behavioural expectation: list of block addresses, final code, latency.
    task automatic build(input longint s, input longint l, input longint f, input int lat);
        longint e;
        longint bs;
        longint be;
        longint a;
        int     k;
        exp_q.delete();
        k = 0;
        if (l == 0) begin
            m_code = 0;
        end else begin
            e  = s + l;
            bs = (s < BND) ? SB : LB;
            be = (e < BND) ? SB : LB;
            if (e > TOT || (s % bs) != 0 || (e % be) != 0) begin
                m_code = 1;
            end else begin
                m_code = 0;
                a = s;
                while (a < e) begin
                    exp_q.push_back(a);
                    k++;
                    if (a == f) begin
                        m_code = 2;
                        break;
                    end
                    a = a + ((a < BND) ? SB : LB);
                end
            end
        end
        m_lat = 2 + k * (lat + 1);
    endtask

    // Model of handshake occupancy, advanced at the rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) m_busy = 1'b0;
        else if (m_busy && sts_valid) m_busy = 1'b0;
        else if (!m_busy && req_valid) begin
            m_busy = 1'b1;
            m_cnt  = 0;
        end
    end

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            longint e;
            if (m_busy) m_cnt++;
            chk(req_ready == !m_busy, "R1 ready", longint'(req_ready), longint'(!m_busy));
            if (ers_go) begin
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected erase", longint'(ers_addr), -1);
                else begin
                    e = exp_q.pop_front();
                    chk(longint'(ers_addr) == e, "R7 erase address", longint'(ers_addr), e);
                end
            end
            if (sts_valid) begin
                chk(int'(sts_code) == m_code, "R9 status code", longint'(sts_code), longint'(m_code));
                chk(exp_q.size() == 0, "R8 blocks left unerased", longint'(exp_q.size()), 0);
                chk(m_cnt == m_lat, "R11 status latency", longint'(m_cnt), longint'(m_lat));
            end
        end
    end

    // Command sequencer stand-in.
    always @(negedge clk) begin
        rsp_done = 1'b0;
        rsp_fail = 1'b0;
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                rsp_done = 1'b1;
                rsp_fail = (pend == fail_at);
            end
        end
        if (rst_n && ers_go) begin
            rsp_cnt = rsp_lat;
            pend    = longint'(ers_addr);
        end
    end

    task automatic run(input longint s, input longint l, input longint f, input int lat);
        fail_at = f;
        rsp_lat = lat;
        build(s, l, f, lat);
        @(negedge clk);
        req_start = s[31:0];
        req_len   = l[31:0];
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 4000 && m_busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", longint'(req_ready), 1);
        chk(sts_valid == 1'b0, "R1 reset status", longint'(sts_valid), 0);
        chk(ers_go == 1'b0, "R6 reset erase", longint'(ers_go), 0);

        run(64'h0, 64'h4000, -1, 1);              // R9 one small block
        run(64'h1_8000, 64'h2_8000, -1, 1);       // R7 crosses into large blocks
        run(64'h0, TOT, -1, 1);                   // R7 R9 whole array
        run(64'h3E_0000, 64'h2_0000, -1, 3);      // R9 last block, ends at total
        run(64'h123, 64'h0, -1, 1);               // R2 zero length, odd start
        run(64'h3E_0000, 64'h4_0000, -1, 1);      // R3 beyond end
        run(64'hFFFE_0000, 64'h4_0000, -1, 1);    // R3 sum beyond 32 bits
        run(64'h1000, 64'h4000, -1, 1);           // R4 small region misaligned
        run(64'h2_4000, 64'h2_0000, -1, 1);       // R4 large region misaligned
        run(64'h0, 64'h2_4000, -1, 1);            // R5 end misaligned, large
        run(64'h0, 64'h2000, -1, 1);              // R5 end misaligned, small
        run(64'h2_0000, 64'h6_0000, 64'h4_0000, 2); // R8 fail on second block
        run(64'h0, 64'h8000, 64'h0, 1);           // R8 fail on first block

        // R10 stray done while idle
        @(negedge clk);
        idle_done = 1'b1;
        @(negedge clk);
        idle_done = 1'b0;
        chk(sts_valid == 1'b0, "R10 stray done status", longint'(sts_valid), 0);
        @(negedge clk);
        chk(req_ready == 1'b1 && sts_valid == 1'b0 && ers_go == 1'b0,
            "R10 stray done idle", longint'({req_ready, sts_valid, ers_go}), 3'b100);
        run(64'h4000, 64'h4000, -1, 1);           // R6 still walks normally

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule